// File: doc/BRIEF.md
# Multi-Core Power State Selector

This block sets the power state of every core in a multi-core converter to normal, nap or sleep. By default the state comes from an external three-level mode pin. That pin is decoded outside the block and arrives here as a 2-bit level. The pin acts on all cores at once.

A 3-bit one-hot mode code can override the pin for any core. Each core has its own stored code. A register write stores its data into every core whose bit is set in the core-select mask. The all-zero code, and any code that is not one of the three one-hot values, hands that core back to the pin.

A hard reset clears all stored codes. A soft reset leaves the codes untouched and only clears the readback register. The stored code of the currently selected core can be read back on a dedicated port.

Top module: `power_mode_sel`

## Requirements
- R1: A hard reset (`rst` high, synchronous) clears every stored code to 000, drives every core state to sleep (10) and drives `rd_code` to 000 while it is held. After release, every core follows the pin.
- R2: A core whose code is 000 takes its state from the pin level. Level 00 (low) gives sleep, 01 (mid) gives normal, 10 (high) gives nap, and the unused level 11 gives normal.
- R3: Code 001 forces a core to normal, code 010 forces nap and code 100 forces sleep, whatever the pin level.
- R4: Any code other than 000, 001, 010 or 100 is stored and read back as written, but the core then follows the pin as if the code were 000.
- R5: A write (`wr_en` high) stores `wr_data` into every core whose `core_sel` bit is set, and into no other core. Several cores can be written at once.
- R6: The pin acts on all cores at once: every core whose code defers to the pin shows the same state in the same cycle.
- R7: `soft_rst` changes no stored code and no core state. A write in the same cycle as `soft_rst` still takes effect.
- R8: A write stores its code at the clock edge where `wr_en` is sampled high. `pwr_state` shows the result one edge later. A change of pin level appears on `pwr_state` one edge after it is sampled.
- R9: `rd_code` is registered. One edge after sampling, it holds the stored code of the lowest-numbered core whose `core_sel` bit is set, or 000 if no bit is set. It reads 000 for the one cycle after `soft_rst` is sampled high.
- R10: Each core's 2-bit field of `pwr_state` (core i at bits 2i+1:2i) is encoded as 00 normal, 01 nap or 10 sleep, and never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Soft reset pulse; stored codes are kept |
| pin_lvl | input | 2 | Decoded mode pin level: 00 low, 01 mid, 10 high |
| wr_en | input | 1 | Mode-code write strobe |
| wr_data | input | 3 | Mode code to store |
| core_sel | input | NUM_CORES | Core-select mask for writes and readback |
| rd_code | output | 3 | Stored code of the lowest selected core |
| pwr_state | output | 2*NUM_CORES | Per-core power state, 2 bits per core |

## Verification
A soft reset and a code write can land in the same cycle. The bench raises `soft_rst` and `wr_en` on the same falling edge. It then checks three things: the written core takes its new forced state two edges later, the other cores keep theirs, and `rd_code` reads 000 for exactly one cycle before it returns the new code. A hard reset that arrives while cores hold forced codes is also checked, by reading back every core's code and confirming that all cores fall back to the pin.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    PS_NORMAL = 2'b00,
    PS_NAP    = 2'b01,
    PS_SLEEP  = 2'b10
  } pstate_e;

  // decoded level of the tri-level pin
  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  function automatic pstate_e lvl_state(input logic [1:0] lvl);
    case (lvl)
      LVL_LOW:  return PS_SLEEP;
      LVL_HIGH: return PS_NAP;
      default:  return PS_NORMAL;
    endcase
  endfunction

  // one-hot codes force a state, anything else defers to the pin
  function automatic pstate_e pick_state(input logic [MODE_W-1:0] code,
                                         input logic [1:0] lvl);
    case (code)
      3'b001:  return PS_NORMAL;
      3'b010:  return PS_NAP;
      3'b100:  return PS_SLEEP;
      default: return lvl_state(lvl);
    endcase
  endfunction
endpackage

// File: rtl/pms_code_bank.sv
module pms_code_bank
  import pms_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int FLAT_W = NUM_CORES * MODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [MODE_W-1:0]    wr_data,
  input  logic [NUM_CORES-1:0] core_sel,
  output logic [FLAT_W-1:0]    code_q
);
  // one holding register per core; soft reset is deliberately absent
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst)
        code_q[c*MODE_W +: MODE_W] <= '0;
      else if (wr_en && core_sel[c])
        code_q[c*MODE_W +: MODE_W] <= wr_data;
    end
  end
endmodule

// File: rtl/pms_state_resolve.sv
module pms_state_resolve
  import pms_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int FLAT_W = NUM_CORES * MODE_W,
  localparam int OUT_W  = NUM_CORES * 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAT_W-1:0] code_q,
  input  logic [1:0]        pin_lvl,
  output logic [OUT_W-1:0]  pwr_state
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst)
        pwr_state[c*2 +: 2] <= PS_SLEEP;
      else
        pwr_state[c*2 +: 2] <= pick_state(code_q[c*MODE_W +: MODE_W], pin_lvl);
    end
  end
endmodule

// File: rtl/pms_readback.sv
module pms_readback
  import pms_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int FLAT_W = NUM_CORES * MODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 soft_rst,
  input  logic [FLAT_W-1:0]    code_q,
  input  logic [NUM_CORES-1:0] core_sel,
  output logic [MODE_W-1:0]    rd_code
);
  logic [MODE_W-1:0] pick;

  // scan downward so the lowest selected core wins
  always_comb begin
    pick = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--)
      if (core_sel[c]) pick = code_q[c*MODE_W +: MODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) rd_code <= '0;
    else                 rd_code <= pick;
  end
endmodule

// File: rtl/power_mode_sel.sv
module power_mode_sel
  import pms_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   soft_rst,
  input  logic [1:0]             pin_lvl,
  input  logic                   wr_en,
  input  logic [2:0]             wr_data,
  input  logic [NUM_CORES-1:0]   core_sel,
  output logic [2:0]             rd_code,
  output logic [2*NUM_CORES-1:0] pwr_state
);
  localparam int FLAT_W = NUM_CORES * MODE_W;

  logic [FLAT_W-1:0] code_q;

  pms_code_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .core_sel(core_sel), .code_q(code_q)
  );

  pms_state_resolve #(.NUM_CORES(NUM_CORES)) u_resolve (
    .clk(clk), .rst(rst), .code_q(code_q), .pin_lvl(pin_lvl),
    .pwr_state(pwr_state)
  );

  pms_readback #(.NUM_CORES(NUM_CORES)) u_rb (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .code_q(code_q),
    .core_sel(core_sel), .rd_code(rd_code)
  );
endmodule

// File: rtl/power_mode_sel_chk.sv
module power_mode_sel_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   soft_rst,
  input logic                   wr_en,
  input logic [2:0]             wr_data,
  input logic [NUM_CORES-1:0]   core_sel,
  input logic [2:0]             rd_code,
  input logic [2*NUM_CORES-1:0] pwr_state,
  input logic [3*NUM_CORES-1:0] code_q
);
  logic all_same;
  always_comb begin
    all_same = 1'b1;
    for (int c = 1; c < NUM_CORES; c++)
      if (pwr_state[c*2 +: 2] != pwr_state[1:0]) all_same = 1'b0;
  end

  // R1: hard reset empties the code bank
  a_r1_hard_clear: assert property (@(posedge clk) rst |=> code_q == '0);

  // R6: with every core deferring, all states agree one edge later
  a_r6_pin_global: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |=> all_same);

  // R7: soft reset without a write leaves the bank alone
  a_r7_soft_hold: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !wr_en) |=> $stable(code_q));

  // R9: readback is zero right after a soft reset
  a_r9_soft_rd_zero: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> rd_code == 3'b000);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // R5: selected cores capture the write data
    a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && core_sel[c]) |=> code_q[c*3 +: 3] == $past(wr_data));
    // R5: other cores keep their code
    a_r5_unsel_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && core_sel[c]) |=> $stable(code_q[c*3 +: 3]));
    // R10: state field never takes the unused encoding
    a_r10_legal: assert property (@(posedge clk) disable iff (rst)
      pwr_state[c*2 +: 2] != 2'b11);
  end
endmodule

bind power_mode_sel power_mode_sel_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
  .wr_data(wr_data), .core_sel(core_sel), .rd_code(rd_code),
  .pwr_state(pwr_state), .code_q(code_q)
);

// File: tb/tb_power_mode_sel.sv
module tb_power_mode_sel;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic [1:0]    pin_lvl = 2'b01;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_data = 3'b000;
  logic [NC-1:0] core_sel = '0;
  logic [2:0]    rd_code;
  logic [2*NC-1:0] pwr_state;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [2:0] mdl [NC];

  always #10 clk = ~clk;

  power_mode_sel #(.NUM_CORES(NC)) dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .pin_lvl(pin_lvl),
    .wr_en(wr_en), .wr_data(wr_data), .core_sel(core_sel),
    .rd_code(rd_code), .pwr_state(pwr_state)
  );

  // expected state from the requirement tables: 00 normal 01 nap 10 sleep
  function automatic logic [1:0] want(input logic [2:0] code, input logic [1:0] lvl);
    if (code == 3'b001) return 2'b00;
    if (code == 3'b010) return 2'b01;
    if (code == 3'b100) return 2'b10;
    if (lvl == 2'b00) return 2'b10;
    if (lvl == 2'b10) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [2:0] want_rd(input logic [NC-1:0] sel);
    for (int c = 0; c < NC; c++) if (sel[c]) return mdl[c];
    return 3'b000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_states(input string req);
    for (int c = 0; c < NC; c++)
      chk(req, 32'(pwr_state[c*2 +: 2]), 32'(want(mdl[c], pin_lvl)));
  endtask

  // R8: state unchanged one cycle after the strobe, updated the next
  task automatic do_write(input logic [NC-1:0] sel, input logic [2:0] code);
    @(negedge clk);
    wr_en = 1'b1; wr_data = code; core_sel = sel;
    @(negedge clk);
    wr_en = 1'b0;
    chk_states("R8");
    for (int c = 0; c < NC; c++) if (sel[c]) mdl[c] = code;
    @(negedge clk);
    chk_states("R8");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", 32'(pwr_state), 32'({NC{2'b10}}));
    chk("R1", 32'(rd_code), 32'h0);
    rst = 1'b0;
    for (int c = 0; c < NC; c++) mdl[c] = 3'b000;
    core_sel = 4'b0001;
    repeat (2) @(negedge clk);
    chk_states("R1");
    chk("R1", 32'(rd_code), 32'h0);
  endtask

  task automatic t_pin_sweep();
    for (int l = 0; l < 4; l++) begin
      pin_lvl = 2'(l);
      @(negedge clk);
      chk_states("R2");
      chk("R6", 32'(pwr_state), 32'({NC{want(3'b000, pin_lvl)}}));
    end
    pin_lvl = 2'b01;
  endtask

  task automatic t_force();
    do_write(4'b0001, 3'b001);
    do_write(4'b0010, 3'b010);
    do_write(4'b0100, 3'b100);
    for (int l = 0; l < 3; l++) begin
      pin_lvl = 2'(l);
      @(negedge clk);
      chk_states("R3");
    end
    core_sel = 4'b0100;
    @(negedge clk);
    chk("R9", 32'(rd_code), 32'h4);
  endtask

  task automatic t_mask();
    do_write(4'b0110, 3'b001);
    chk("R5", 32'(rd_code), 32'h1);
    chk("R5", 32'(pwr_state[1:0]), 32'(want(3'b010, pin_lvl)) & 32'h0 | 32'(want(mdl[0], pin_lvl)));
    do_write(4'b1001, 3'b100);
    chk_states("R5");
  endtask

  task automatic t_illegal();
    logic [2:0] bad [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
    for (int k = 0; k < 4; k++) begin
      do_write(4'b1000, bad[k]);
      chk("R4", 32'(rd_code), 32'(bad[k]));
      pin_lvl = 2'b10;
      @(negedge clk);
      chk("R4", 32'(pwr_state[7:6]), 32'h1);
      pin_lvl = 2'b00;
      @(negedge clk);
      chk("R4", 32'(pwr_state[7:6]), 32'h2);
    end
    pin_lvl = 2'b01;
  endtask

  task automatic t_soft();
    core_sel = 4'b0010;
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R9", 32'(rd_code), 32'h0);
    chk_states("R7");
    @(negedge clk);
    chk("R7", 32'(rd_code), 32'(want_rd(core_sel)));
    chk_states("R7");
    // soft reset and write together
    @(negedge clk);
    soft_rst = 1'b1; wr_en = 1'b1; wr_data = 3'b010; core_sel = 4'b0010;
    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b0;
    chk("R9", 32'(rd_code), 32'h0);
    chk_states("R8");
    mdl[1] = 3'b010;
    @(negedge clk);
    chk("R7", 32'(rd_code), 32'h2);
    chk_states("R7");
  endtask

  task automatic t_hard();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NC; c++) mdl[c] = 3'b000;
    @(negedge clk);
    chk_states("R1");
    for (int c = 0; c < NC; c++) begin
      core_sel = NC'(1 << c);
      @(negedge clk);
      chk("R1", 32'(rd_code), 32'h0);
    end
  endtask

  task automatic t_rb_none();
    do_write(4'b0100, 3'b100);
    core_sel = '0;
    @(negedge clk);
    chk("R9", 32'(rd_code), 32'h0);
    core_sel = 4'b1100;
    @(negedge clk);
    chk("R9", 32'(rd_code), 32'h4);
    chk("R10", 32'(pwr_state[5:4]), 32'h2);
  endtask

  initial begin
    t_reset();
    t_pin_sweep();
    t_force();
    t_mask();
    t_illegal();
    t_soft();
    t_hard();
    t_rb_none();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule